// File: doc/BRIEF.md
# Synchronous Receive Hunt and SYN Detector

This block is the front end of a synchronous serial receiver. It takes one data bit per 1X receive clock, presented as a single-cycle `bit_stb` strobe in the system clock domain. After the receive enable rises, it searches the bit stream one bit at a time for a programmed sync character, SYN1. Once it has locked on, it frames the following bits into characters of 5 to 8 data bits. Each character may be followed by an optional even or odd parity bit. Completed characters are placed in a holding register, and a ready flag is raised.

Two kinds of lock are supported. A single SYN1 match is enough for lock, or a two-character handshake can be required: SYN1 must be immediately followed by SYN2. If the second character is not SYN2, the search starts again. Characters equal to a SYN pattern can be dropped instead of being delivered. An external sync input can replace the internal pattern search, so that framing starts on a chosen bit. The control and status bits are plain levels and strobes, for a register block elsewhere to drive and read.

States: `ST_IDLE` (enable low), `ST_HUNT` (bit-by-bit SYN1 search), `ST_SYN2` (framing the character that must equal SYN2), `ST_CHAR` (locked, framing characters). The transitions are:
- enable low → `ST_IDLE` from any state.
- enable rising → `ST_HUNT` from any state.
- SYN1 match in `ST_HUNT` → `ST_CHAR` (single mode) or `ST_SYN2` (double mode).
- `ST_SYN2` character done → `ST_CHAR` if it equals SYN2, otherwise back to `ST_HUNT`.
- external sync edge plus a bit strobe → `ST_CHAR` from any active state.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, `rdy`, `syn_det`, `par_err`, `ovr_err` and `hold_data` are all zero.
- R2: A rising edge of `rx_en` starts a hunt. In single mode, the first window of frame bits that equals SYN1 ends the hunt and sets `syn_det`, at whatever bit offset it starts. That SYN1 is never written to the holding register.
- R3: Once locked, every frame (`char_len`+5 data bits sent LSB first, then the parity bit if enabled) is written to `hold_data` and sets `rdy`. Unused upper bits are zero.
- R4: In double mode, lock needs SYN1 followed directly by SYN2. If the character after SYN1 is not SYN2, the hunt restarts, so SYN1-SYN1-SYN2 gives no lock and no character.
- R5: While locked, a SYN1 character (single mode) or SYN1 followed by SYN2 (double mode) sets `syn_det` again. With `strip_syn`=1, characters equal to SYN1, or in double mode to SYN2, are not written. With `strip_syn`=0 they are written.
- R6: With `par_en`=1, the parity bit must equal the XOR of the data bits, inverted when `par_odd`=1. `par_err` shows whether the character in the holding register failed that check. A SYN1 with a bad parity bit does not end the hunt.
- R7: `ovr_err` is set when a character is written while `rdy` is still set.
- R8: A `rd_data` strobe clears `rdy`. `rx_en` low clears `rdy`.
- R9: While `dcd_n` is high, bit strobes are ignored: no bit is counted and no output changes.
- R10: With `ext_en`=1, the internal SYN1 search is off. After a rising edge of `ext_sync`, the next bit strobe is taken as the first bit of a character, and `syn_det` is set. It stays set until a `rd_status` strobe.
- R11: A `rd_status` strobe clears `syn_det` and `ovr_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_stb | input | 1 | Receive clock rising-edge strobe, one cycle wide |
| rx_data | input | 1 | Serial data, sampled with `bit_stb` |
| rx_en | input | 1 | Receiver enable; a rising edge starts a hunt |
| dcd_n | input | 1 | Carrier detect, active low |
| syn1 | input | CHAR_W | First sync pattern |
| syn2 | input | CHAR_W | Second sync pattern |
| char_len | input | LEN_W | Data bits per character minus MIN_LEN |
| dbl_syn | input | 1 | 1 = two-character sync handshake |
| strip_syn | input | 1 | 1 = drop SYN characters |
| par_en | input | 1 | 1 = a parity bit follows the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| ext_en | input | 1 | 1 = external sync replaces the pattern search |
| ext_sync | input | 1 | External sync, rising edge active |
| rd_data | input | 1 | Holding register read strobe |
| rd_status | input | 1 | Status read strobe |
| hold_data | output | CHAR_W | Received character, zero-filled |
| rdy | output | 1 | Character waiting |
| syn_det | output | 1 | Sync detected |
| par_err | output | 1 | Parity error on the held character |
| ovr_err | output | 1 | Overrun |

## Verification
The bench uses the default parameters, CHAR_W=8 and MIN_LEN=5. This makes every character length from 5 to 8 reachable, and with parity on, the full 9-bit frame window. Lengths 5, 7 and 8 are exercised against fixed SYN patterns. The lead-in mark bits before each SYN1 are chosen so that no earlier window can alias the pattern. This lets the bench place the SYN at a random bit offset and still know the exact bit on which lock must occur.

// File: rtl/sh_pkg.sv
package sh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HUNT = 2'd1,
        ST_SYN2 = 2'd2,
        ST_CHAR = 2'd3
    } sh_state_e;
endpackage

// File: rtl/sh_shift.sv
// Serial-in shift register; the newest bit enters at the top.
module sh_shift #(
    parameter int FR_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    input  logic            din,
    output logic [FR_W-1:0] win
);
    logic [FR_W-1:0] sr_q;

    assign win = {din, sr_q[FR_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sr_q <= '0;
        else if (step)
            sr_q <= win;
    end
endmodule

// File: rtl/sh_frame.sv
// Pulls the data bits and parity status out of the frame window.
module sh_frame #(
    parameter int CHAR_W  = 8,
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2,
    parameter int CNT_W   = 4
) (
    input  logic [CHAR_W:0]   win,
    input  logic [LEN_W-1:0]  len,
    input  logic              par_en,
    input  logic              par_odd,
    output logic [CHAR_W-1:0] data,
    output logic [CHAR_W-1:0] mask,
    output logic              par_ok,
    output logic [CNT_W-1:0]  f_len
);
    localparam int FR_W = CHAR_W + 1;

    logic [CNT_W-1:0] n_bits;
    logic [FR_W-1:0]  aligned;

    always_comb begin
        n_bits  = CNT_W'(MIN_LEN) + CNT_W'(len);
        f_len   = n_bits + CNT_W'(par_en);
        aligned = win >> (CNT_W'(FR_W) - f_len);
        mask    = {CHAR_W{1'b1}} >> (CNT_W'(CHAR_W) - n_bits);
        data    = aligned[CHAR_W-1:0] & mask;
        par_ok  = !par_en || (win[FR_W-1] == ((^data) ^ par_odd));
    end
endmodule

// File: rtl/sh_match.sv
// Compares a framed character with one SYN pattern.
module sh_match #(
    parameter int CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] data,
    input  logic [CHAR_W-1:0] pat,
    input  logic [CHAR_W-1:0] mask,
    input  logic              par_ok,
    output logic              hit
);
    assign hit = par_ok && (data == (pat & mask));
endmodule

// File: rtl/sh_fsm.sv
// Hunt / handshake / framing controller.
module sh_fsm
    import sh_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             dcd_n,
    input  logic             bit_stb,
    input  logic             ext_en,
    input  logic             ext_sync,
    input  logic             dbl_syn,
    input  logic             strip_syn,
    input  logic [CNT_W-1:0] f_len,
    input  logic             hit1,
    input  logic             hit2,
    output logic             step,
    output logic             xfer,
    output logic             syn_hit
);
    sh_state_e        state, st_n;
    logic [CNT_W-1:0] cnt, cnt_n, cnt_inc;
    logic             prev1, prev1_n;
    logic             en_q, ext_q, pend, pend_n;
    logic             ext_edge;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            prev1 <= 1'b0;
            en_q  <= 1'b0;
            ext_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            state <= st_n;
            cnt   <= cnt_n;
            prev1 <= prev1_n;
            en_q  <= rx_en;
            ext_q <= ext_sync;
            pend  <= pend_n;
        end
    end

    // next state and output strobes
    always_comb begin
        step     = rx_en && !dcd_n && bit_stb;
        ext_edge = ext_en && ext_sync && !ext_q;
        cnt_inc  = cnt + 1'b1;
        st_n     = state;
        cnt_n    = cnt;
        prev1_n  = prev1;
        pend_n   = (pend || ext_edge) && ext_en;
        xfer     = 1'b0;
        syn_hit  = 1'b0;
        if (!rx_en) begin
            st_n    = ST_IDLE;
            cnt_n   = '0;
            prev1_n = 1'b0;
            pend_n  = 1'b0;
        end else if (!en_q) begin
            st_n    = ST_HUNT;
            cnt_n   = '0;
            prev1_n = 1'b0;
        end else if (step && (pend || ext_edge)) begin
            st_n    = ST_CHAR;
            cnt_n   = CNT_W'(1);
            prev1_n = 1'b0;
            syn_hit = 1'b1;
            pend_n  = 1'b0;
        end else if (step) begin
            unique case (state)
                ST_IDLE: begin
                    st_n = ST_HUNT;
                end
                ST_HUNT: begin
                    if (!ext_en) begin
                        if (cnt_inc >= f_len && hit1) begin
                            cnt_n = '0;
                            if (dbl_syn) begin
                                st_n = ST_SYN2;
                            end else begin
                                st_n    = ST_CHAR;
                                syn_hit = 1'b1;
                            end
                        end else if (cnt < f_len) begin
                            cnt_n = cnt_inc;
                        end
                    end
                end
                ST_SYN2: begin
                    if (cnt_inc >= f_len) begin
                        cnt_n = '0;
                        if (hit2) begin
                            st_n    = ST_CHAR;
                            syn_hit = 1'b1;
                        end else begin
                            st_n = ST_HUNT;
                        end
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
                ST_CHAR: begin
                    if (cnt_inc >= f_len) begin
                        cnt_n   = '0;
                        prev1_n = hit1;
                        if (!ext_en)
                            syn_hit = dbl_syn ? (prev1 && hit2) : hit1;
                        xfer = !(strip_syn && (hit1 || (dbl_syn && hit2)));
                    end else begin
                        cnt_n = cnt_inc;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sync_hunt_rx.sv
module sync_hunt_rx #(
    parameter int CHAR_W  = 8,
    parameter int MIN_LEN = 5,
    localparam int LEN_W  = $clog2(CHAR_W - MIN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              rx_data,
    input  logic              rx_en,
    input  logic              dcd_n,
    input  logic [CHAR_W-1:0] syn1,
    input  logic [CHAR_W-1:0] syn2,
    input  logic [LEN_W-1:0]  char_len,
    input  logic              dbl_syn,
    input  logic              strip_syn,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              ext_en,
    input  logic              ext_sync,
    input  logic              rd_data,
    input  logic              rd_status,
    output logic [CHAR_W-1:0] hold_data,
    output logic              rdy,
    output logic              syn_det,
    output logic              par_err,
    output logic              ovr_err
);
    localparam int FR_W  = CHAR_W + 1;
    localparam int CNT_W = $clog2(FR_W + 1);
    localparam int N_SYN = 2;

    logic [FR_W-1:0]   win;
    logic [CHAR_W-1:0] data, mask;
    logic              par_ok, step, xfer, syn_hit;
    logic [CNT_W-1:0]  f_len;
    logic [N_SYN-1:0]  hits;
    logic [CHAR_W-1:0] pats [N_SYN];

    assign pats[0] = syn1;
    assign pats[1] = syn2;

    sh_shift #(.FR_W(FR_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .step(step), .din(rx_data), .win(win)
    );

    sh_frame #(.CHAR_W(CHAR_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_frame (
        .win(win), .len(char_len), .par_en(par_en), .par_odd(par_odd),
        .data(data), .mask(mask), .par_ok(par_ok), .f_len(f_len)
    );

    for (genvar g = 0; g < N_SYN; g++) begin : g_match
        sh_match #(.CHAR_W(CHAR_W)) u_match (
            .data(data), .pat(pats[g]), .mask(mask), .par_ok(par_ok), .hit(hits[g])
        );
    end

    sh_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .dcd_n(dcd_n), .bit_stb(bit_stb),
        .ext_en(ext_en), .ext_sync(ext_sync), .dbl_syn(dbl_syn), .strip_syn(strip_syn),
        .f_len(f_len), .hit1(hits[0]), .hit2(hits[1]),
        .step(step), .xfer(xfer), .syn_hit(syn_hit)
    );

    // holding register and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            rdy       <= 1'b0;
            syn_det   <= 1'b0;
            par_err   <= 1'b0;
            ovr_err   <= 1'b0;
        end else begin
            syn_det <= syn_hit || (syn_det && !rd_status);
            if (xfer) begin
                hold_data <= data;
                par_err   <= !par_ok;
                ovr_err   <= ovr_err || (rdy && !rd_data);
                rdy       <= 1'b1;
            end else begin
                if (rd_data || !rx_en)
                    rdy <= 1'b0;
                if (rd_status)
                    ovr_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sync_hunt_rx_chk.sv
module sync_hunt_rx_chk #(
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_stb,
    input logic              rx_en,
    input logic              dcd_n,
    input logic              rd_data,
    input logic              rd_status,
    input logic [CHAR_W-1:0] hold_data,
    input logic              rdy,
    input logic              syn_det,
    input logic              ovr_err
);
    p_disabled_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rdy);

    p_read_clears_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !bit_stb) |=> !rdy);

    p_status_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !bit_stb) |=> (!syn_det && !ovr_err));

    p_overrun_needs_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> $past(rdy));

    p_hold_moves_on_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hold_data) |-> $past(bit_stb));

    p_no_carrier_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dcd_n && rx_en && !rd_data && !rd_status)
        |=> ($stable(rdy) && $stable(hold_data) && $stable(syn_det)));
endmodule

bind sync_hunt_rx sync_hunt_rx_chk #(.CHAR_W(CHAR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_en(rx_en), .dcd_n(dcd_n),
    .rd_data(rd_data), .rd_status(rd_status), .hold_data(hold_data),
    .rdy(rdy), .syn_det(syn_det), .ovr_err(ovr_err)
);

// File: tb/test_sync_hunt_rx.sv
module test_sync_hunt_rx;
    logic       clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0, rx_data = 1'b1;
    logic       rx_en = 1'b0, dcd_n = 1'b0, dbl_syn = 1'b0, strip_syn = 1'b0;
    logic       par_en = 1'b0, par_odd = 1'b0, ext_en = 1'b0, ext_sync = 1'b0;
    logic       rd_data = 1'b0, rd_status = 1'b0;
    logic [1:0] char_len = 2'd3;
    logic [7:0] syn1 = 8'h16, syn2 = 8'h32;
    logic [7:0] hold_data;
    logic       rdy, syn_det, par_err, ovr_err;
    int         errs = 0, checks = 0;
    int         nb = 8;
    bit         done = 1'b0;

    sync_hunt_rx i_sync_hunt_rx (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_data(rx_data), .rx_en(rx_en),
        .dcd_n(dcd_n), .syn1(syn1), .syn2(syn2), .char_len(char_len), .dbl_syn(dbl_syn),
        .strip_syn(strip_syn), .par_en(par_en), .par_odd(par_odd), .ext_en(ext_en),
        .ext_sync(ext_sync), .rd_data(rd_data), .rd_status(rd_status),
        .hold_data(hold_data), .rdy(rdy), .syn_det(syn_det), .par_err(par_err),
        .ovr_err(ovr_err)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] msk(logic [7:0] d, int n);
        return d & 8'((1 << n) - 1);
    endfunction

    function automatic logic pbit(logic [7:0] d, logic odd);
        return (^d) ^ odd;
    endfunction

    task automatic send_bit(logic b);
        @(negedge clk); rx_data = b; bit_stb = 1'b1;
        @(negedge clk); bit_stb = 1'b0;
    endtask

    task automatic send_char(logic [7:0] d, logic bad);
        for (int i = 0; i < nb; i++) send_bit(d[i]);
        if (par_en) send_bit(pbit(msk(d, nb), par_odd) ^ bad);
    endtask

    task automatic marks(int k);
        for (int i = 0; i < k; i++) send_bit(1'b1);
    endtask

    task automatic read_hold;
        @(negedge clk); rd_data = 1'b1;
        @(negedge clk); rd_data = 1'b0;
    endtask

    task automatic read_stat;
        @(negedge clk); rd_status = 1'b1;
        @(negedge clk); rd_status = 1'b0;
    endtask

    task automatic restart(int n);
        @(negedge clk); rx_en = 1'b0; nb = n; char_len = 2'(n - 5);
        @(negedge clk); rx_en = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [7:0] pick(int n);
        logic [7:0] d;
        d = msk(8'($urandom), n);
        while (d == msk(syn1, n) || d == msk(syn2, n)) d = msk(8'($urandom), n);
        return d;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, d2;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        chk("R1 rdy", rdy, 0); chk("R1 syn_det", syn_det, 0);
        chk("R1 par_err", par_err, 0); chk("R1 ovr_err", ovr_err, 0);
        chk("R1 hold", hold_data, 0);
        rst_n = 1'b1;

        // R2: single SYN at a random offset
        restart(8);
        marks($urandom_range(0, 6));
        chk("R2 no early lock", syn_det, 0);
        send_char(syn1, 0);
        chk("R2 lock", syn_det, 1);
        chk("R2 SYN not held", rdy, 0);
        read_stat;
        chk("R11 syn_det cleared", syn_det, 0);

        // R3: random characters, 8 bits
        for (int k = 0; k < 6; k++) begin
            d = pick(8);
            send_char(d, 0);
            chk("R3 rdy", rdy, 1); chk("R3 data", hold_data, d);
            read_hold;
            chk("R8 read clears rdy", rdy, 0);
        end

        // R7 overrun
        d = pick(8); d2 = pick(8);
        send_char(d, 0); send_char(d2, 0);
        chk("R7 overrun", ovr_err, 1); chk("R7 newest kept", hold_data, d2);
        read_stat;
        chk("R11 ovr cleared", ovr_err, 0);
        read_hold;

        // R5 stripping in single mode
        strip_syn = 1'b1;
        send_char(syn1, 0);
        chk("R5 stripped", rdy, 0); chk("R5 resync", syn_det, 1);
        read_stat;
        strip_syn = 1'b0;
        send_char(syn1, 0);
        chk("R5 kept rdy", rdy, 1); chk("R5 kept data", hold_data, syn1);
        chk("R5 resync kept", syn_det, 1);
        read_hold; read_stat;

        // R3 five-bit characters, zero fill; R8 disable clears rdy
        restart(5);
        marks($urandom_range(0, 6));
        send_char(syn1, 0);
        chk("R2 lock len5", syn_det, 1);
        read_stat;
        for (int k = 0; k < 3; k++) begin
            d = pick(5);
            send_char(d, 0);
            chk("R3 len5 data", hold_data, d);
            read_hold;
        end
        send_char(pick(5), 0);
        chk("R3 len5 rdy", rdy, 1);
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk);
        chk("R8 disable clears rdy", rdy, 0);

        // R4 double SYN
        dbl_syn = 1'b1;
        restart(8);
        read_stat;
        marks(3);
        send_char(syn1, 0); send_char(syn1, 0); send_char(syn2, 0);
        chk("R4 S1-S1-S2 no lock", syn_det, 0);
        chk("R4 S1-S1-S2 no char", rdy, 0);
        send_char(syn1, 0); send_char(syn2, 0);
        chk("R4 S1-S2 lock", syn_det, 1);
        chk("R4 SYNs not held", rdy, 0);
        read_stat;
        strip_syn = 1'b1;
        send_char(syn1, 0); send_char(syn2, 0);
        chk("R5 dbl stripped", rdy, 0); chk("R5 dbl resync", syn_det, 1);
        strip_syn = 1'b0;
        read_stat;
        d = pick(8);
        send_char(d, 0);
        chk("R4 data after lock", hold_data, d);
        read_hold;
        dbl_syn = 1'b0;

        // R6 parity, 7 bits
        par_en = 1'b1;
        restart(7);
        read_stat;
        marks(3);
        send_char(syn1, 1);
        chk("R6 bad-parity SYN no lock", syn_det, 0);
        marks(4);
        send_char(syn1, 0);
        chk("R6 lock", syn_det, 1);
        read_stat;
        d = pick(7);
        send_char(d, 0);
        chk("R6 even ok", par_err, 0); chk("R6 data", hold_data, d);
        read_hold;
        d = pick(7);
        send_char(d, 1);
        chk("R6 even bad", par_err, 1); chk("R6 data bad", hold_data, d);
        read_hold;
        par_odd = 1'b1;
        send_char(pick(7), 0);
        chk("R6 odd ok", par_err, 0);
        read_hold;
        par_en = 1'b0; par_odd = 1'b0;

        // R9 carrier loss
        restart(8);
        marks(2); send_char(syn1, 0);
        read_stat;
        dcd_n = 1'b1;
        send_char(8'hA5, 0);
        chk("R9 ignored rdy", rdy, 0); chk("R9 ignored syn", syn_det, 0);
        dcd_n = 1'b0;
        d = pick(8);
        send_char(d, 0);
        chk("R9 framing kept", hold_data, d);
        read_hold;

        // R10 external sync
        ext_en = 1'b1;
        restart(8);
        read_stat;
        marks(3); send_char(syn1, 0);
        chk("R10 internal off", syn_det, 0);
        chk("R10 no char", rdy, 0);
        @(negedge clk); ext_sync = 1'b1;
        @(negedge clk);
        d = pick(8);
        send_char(d, 0);
        chk("R10 char", hold_data, d); chk("R10 rdy", rdy, 1);
        chk("R10 syn_det", syn_det, 1);
        read_hold;
        send_char(pick(8), 0);
        chk("R10 syn_det held", syn_det, 1);
        read_stat;
        chk("R11 ext syn_det cleared", syn_det, 0);
        ext_sync = 1'b0; ext_en = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule